// File: doc/BRIEF.md
# FPGA Passive Configuration Loader

This block loads a bitstream into a target FPGA through its passive configuration pins. A host pulses `start_i` with a byte count and a mode. The block then pulses the active-low configuration reset for a timed width and waits a settle time. It accepts bitstream bytes over a valid/ready handshake and clocks each byte into the target. Three modes are supported: one bit per clock, a whole byte per clock, and a whole byte held for four clocks for protected streams.

Before each byte is taken, the target's status line is checked. A low status stops the load with a failure and a one-cycle abort pulse. After the last byte the block raises the configuration clock once more and waits a done-settle time. It then samples the done input and reports success or failure. Every delay is given in microseconds and turned into system clocks from the clock-frequency parameter. The two clock phase widths are given directly in system clocks.

Top module: `cfg_loader`

## Requirements
- R1: Out of reset, `cfg_n_o` is high and `dclk_o`, `busy_o`, `ready_o`, `ok_o`, `fail_o` and `abort_o` are low.
- R2: A start taken in idle with a nonzero count and a mode of 0, 1 or 2 raises `busy_o` and drives `cfg_n_o` low for exactly RST_CYC cycles. RST_CYC is RST_US microseconds rounded up to whole clocks.
- R3: `dclk_o` stays low while `cfg_n_o` is low. The first rising edge of `dclk_o` comes at least SETTLE_CYC cycles after `cfg_n_o` rises.
- R4: Mode 0 (serial) gives 8 rising edges of `dclk_o` per byte. The byte is presented least significant bit first on `data_o[0]`, and `data_o[7:1]` is zero.
- R5: Mode 1 (parallel) gives one rising edge per byte, with the whole byte on `data_o`.
- R6: Mode 2 (protected parallel) gives four rising edges per byte, with the byte held on `data_o` for all four.
- R7: `data_o` never changes while `dclk_o` is high, nor in the cycle in which `dclk_o` rises.
- R8: `ready_o` is high only while `status_i` is high and the clock is low between pulses. A low `status_i` when a byte is due ends the load with `fail_o`, one `abort_o` pulse and no further clock edges.
- R9: After the last byte, one more rising edge is driven. `dclk_o` stays high for DONE_CYC cycles, and then `done_i` is sampled: high gives `ok_o`, low gives `fail_o` plus one `abort_o` pulse.
- R10: A start with a count of zero, or with mode 3, sets `fail_o` at the next edge. It does not move `cfg_n_o` or `dclk_o`, does not pulse `abort_o`, and leaves `busy_o` low.
- R11: `ok_o` and `fail_o` hold until the next start in idle, which clears them. `abort_o` is never high for two cycles running.
- R12: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (idle only) |
| mode_i | input | 2 | 0 serial, 1 parallel, 2 protected parallel, 3 invalid |
| count_i | input | CNT_W | Number of bytes to load |
| data_i | input | 8 | Bitstream byte |
| valid_i | input | 1 | `data_i` is valid |
| ready_o | output | 1 | Byte accepted when high with `valid_i` |
| cfg_n_o | output | 1 | Configuration reset to target, active low |
| dclk_o | output | 1 | Configuration clock to target |
| data_o | output | 8 | Configuration data to target (bit 0 in serial mode) |
| status_i | input | 1 | Target status, low means error |
| done_i | input | 1 | Target configuration done |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load succeeded |
| fail_o | output | 1 | Last load failed |
| abort_o | output | 1 | One-cycle pulse on a failure during a load |

## Verification
A status drop and a byte offer can land in the same cycle. The bench keeps `valid_i` high with the next byte ready while it pulls `status_i` low right after the second clock edge of a parallel load. The status check must win: no third edge may appear, and the load must end in failure with a single abort pulse. A late start pulse can also arrive while a parallel load is still running. That load must end exactly as an undisturbed one would.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    MODE_SER = 2'd0,
    MODE_PAR = 2'd1,
    MODE_SEC = 2'd2,
    MODE_BAD = 2'd3
  } cfg_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_SETTLE, ST_FETCH, ST_SETUP, ST_HIGH, ST_GAP, ST_TRAIL
  } cfg_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import cfg_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              serial_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              shift_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] sr_q;
  logic              ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      ser_q <= 1'b0;
    end else if (load_i) begin
      sr_q  <= byte_i;
      ser_q <= serial_i;
    end else if (shift_i) begin
      sr_q  <= sr_q >> 1;
    end
  end

  assign data_o = ser_q ? {{(BYTE_W-1){1'b0}}, sr_q[0]} : sr_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int unsigned RST_US      = 5,
  parameter int unsigned SETTLE_US   = 100,
  parameter int unsigned DONE_US     = 100,
  parameter int unsigned CLK_HI_CYC  = 1,
  parameter int unsigned CLK_LO_CYC  = 1,
  parameter int unsigned CNT_W       = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             cfg_n_o,
  output logic             dclk_o,
  output logic [7:0]       data_o,
  input  logic             status_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             ok_o,
  output logic             fail_o,
  output logic             abort_o
);
  localparam longint HZ       = longint'(CLK_FREQ_HZ);
  localparam longint RST_L    = (HZ * RST_US + 999_999) / 1_000_000;
  localparam longint SETTLE_L = (HZ * SETTLE_US + 999_999) / 1_000_000;
  localparam longint DONE_L   = (HZ * DONE_US + 999_999) / 1_000_000;
  localparam int RST_CYC    = (RST_L < 1) ? 1 : int'(RST_L);
  localparam int SETTLE_CYC = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);
  localparam int DONE_CYC   = (DONE_L < 1) ? 1 : int'(DONE_L);
  localparam int HI_CYC     = (CLK_HI_CYC < 1) ? 1 : int'(CLK_HI_CYC);
  localparam int LO_CYC     = (CLK_LO_CYC < 1) ? 1 : int'(CLK_LO_CYC);
  localparam int MAX_A      = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAX_B      = (DONE_CYC > HI_CYC) ? DONE_CYC : HI_CYC;
  localparam int MAX_C      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC    = (MAX_C > LO_CYC) ? MAX_C : LO_CYC;
  localparam int TMR_W      = $clog2(MAX_CYC + 1);

  cfg_state_e       state_q, state_d;
  cfg_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [2:0]       pulses_q, pulses_d;
  logic             ok_q, ok_d, fail_q, fail_d, abort_q, abort_d;
  logic             tmr_load, tmr_zero, sh_load, sh_shift;
  logic [TMR_W-1:0] tmr_val;

  cfg_timer #(.W(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  cfg_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .serial_i(mode_q == MODE_SER),
    .byte_i(data_i), .shift_i(sh_shift), .data_o(data_o)
  );

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    left_d   = left_q;
    pulses_d = pulses_q;
    ok_d     = ok_q;
    fail_d   = fail_q;
    abort_d  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ok_d   = 1'b0;
        mode_d = cfg_mode_e'(mode_i);
        left_d = count_i;
        if (count_i == '0 || cfg_mode_e'(mode_i) == MODE_BAD) begin
          fail_d = 1'b1;
        end else begin
          fail_d   = 1'b0;
          state_d  = ST_RST;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RST_CYC - 1);
        end
      end
      ST_RST: if (tmr_zero) begin
        state_d  = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETTLE_CYC - 1);
      end
      ST_SETTLE: if (tmr_zero) state_d = ST_FETCH;
      ST_FETCH: begin
        if (!status_i) begin
          fail_d  = 1'b1;
          abort_d = 1'b1;
          state_d = ST_IDLE;
        end else if (valid_i) begin
          sh_load  = 1'b1;
          left_d   = left_q - 1'b1;
          pulses_d = (mode_q == MODE_SER) ? 3'd7 : (mode_q == MODE_SEC) ? 3'd3 : 3'd0;
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(LO_CYC - 1);
        end
      end
      ST_SETUP: if (tmr_zero) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HI_CYC - 1);
      end
      ST_HIGH: if (tmr_zero) state_d = ST_GAP;
      ST_GAP: begin
        // one low cycle after the fall before data may move
        if (pulses_q != '0) begin
          pulses_d = pulses_q - 1'b1;
          sh_shift = (mode_q == MODE_SER);
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(LO_CYC - 1);
        end else if (left_q != '0) begin
          state_d = ST_FETCH;
        end else begin
          state_d  = ST_TRAIL;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(DONE_CYC - 1);
        end
      end
      ST_TRAIL: if (tmr_zero) begin
        state_d = ST_IDLE;
        if (done_i) ok_d = 1'b1;
        else begin
          fail_d  = 1'b1;
          abort_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_SER;
      left_q   <= '0;
      pulses_q <= '0;
      ok_q     <= 1'b0;
      fail_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      left_q   <= left_d;
      pulses_q <= pulses_d;
      ok_q     <= ok_d;
      fail_q   <= fail_d;
      abort_q  <= abort_d;
    end
  end

  assign cfg_n_o = (state_q != ST_RST);
  assign dclk_o  = (state_q == ST_HIGH) || (state_q == ST_TRAIL);
  assign ready_o = (state_q == ST_FETCH) && status_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign ok_o    = ok_q;
  assign fail_o  = fail_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ready_o,
  input logic       status_i,
  input logic       cfg_n_o,
  input logic       dclk_o,
  input logic [7:0] data_o,
  input logic       busy_o,
  input logic       ok_o,
  input logic       fail_o,
  input logic       abort_o
);
  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cfg_n_o && !dclk_o && !ready_o));

  // R3
  rst_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_n_o |-> (!dclk_o && busy_o));

  // R7
  data_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o));

  // R7
  data_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |-> $stable(data_o));

  // R8
  ready_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (status_i && !dclk_o && cfg_n_o));

  // R11
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  // R11
  result_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fail_o));

  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!busy_o && !start_i) && !busy_o) |-> ($stable(ok_o) && $stable(fail_o)));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
  .status_i(status_i), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o), .data_o(data_o),
  .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o), .abort_o(abort_o)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int CNT_W = 16;
  localparam int RSTC = 10;
  localparam int SETC = 200;
  localparam int DONC = 200;
  localparam int CAPN = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [CNT_W-1:0] count = '0;
  logic [7:0] din = '0;
  logic valid = 1'b0;
  logic status = 1'b1;
  logic done = 1'b1;
  logic ready, cfg_n, dclk, busy, ok, fail, abort_p;
  logic [7:0] dout;

  int total = 0, bad = 0, cyc = 0;
  int rises, cfgn_low, cfgn_rise_cyc, first_rise, last_rise, end_cyc, abort_cnt, drop_at;
  logic prev_cfgn = 1'b1, prev_dclk = 1'b0, prev_busy = 1'b0;
  logic [7:0] cap [CAPN];
  logic [7:0] src [32];

  always #4 clk = ~clk;

  cfg_loader #(
    .CLK_FREQ_HZ(2_000_000), .RST_US(5), .SETTLE_US(100), .DONE_US(100),
    .CLK_HI_CYC(2), .CLK_LO_CYC(1), .CNT_W(CNT_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .count_i(count),
    .data_i(din), .valid_i(valid), .ready_o(ready), .cfg_n_o(cfg_n), .dclk_o(dclk),
    .data_o(dout), .status_i(status), .done_i(done), .busy_o(busy), .ok_o(ok),
    .fail_o(fail), .abort_o(abort_p)
  );

  always @(negedge clk) begin
    cyc++;
    if (!cfg_n) cfgn_low++;
    if (cfg_n && !prev_cfgn) cfgn_rise_cyc = cyc;
    if (dclk && !prev_dclk) begin
      if (rises < CAPN) cap[rises] = dout;
      if (rises == 0) first_rise = cyc;
      last_rise = cyc;
      rises++;
    end
    if (abort_p) abort_cnt++;
    if (!busy && prev_busy) end_cyc = cyc;
    if (drop_at >= 0 && rises >= drop_at) status = 1'b0;
    prev_cfgn = cfg_n;
    prev_dclk = dclk;
    prev_busy = busy;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; cfgn_low = 0; cfgn_rise_cyc = 0; first_rise = 0;
    last_rise = 0; end_cyc = 0; abort_cnt = 0; drop_at = -1;
  endtask

  task automatic run_load(input logic [1:0] m, input int n, input int seed, input bit poke);
    int k;
    for (int i = 0; i < 32; i++) src[i] = 8'(seed * 37 + i * 91 + (i >> 1));
    @(negedge clk);
    clear_mon();
    mode = m; count = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    valid = 1'b1; din = src[0];
    while (busy && k < n) begin
      if (ready) begin
        @(posedge clk);
        k++;
        @(negedge clk);
        if (k < n) din = src[k];
        else valid = 1'b0;
        if (poke && k == 1) begin
          start = 1'b1; mode = 2'd0; count = '0;
          @(negedge clk);
          start = 1'b0;
        end
      end else begin
        @(negedge clk);
      end
    end
    valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cfg_n === 1'b1, "R1 cfg_n", int'(cfg_n), 1);
    chk(dclk === 1'b0, "R1 dclk", int'(dclk), 0);
    chk(busy === 1'b0 && ready === 1'b0, "R1 busy/ready", int'({busy, ready}), 0);
    chk(ok === 1'b0 && fail === 1'b0 && abort_p === 1'b0, "R1 results",
        int'({ok, fail, abort_p}), 0);
  endtask

  task automatic common_ok(input int n, input int ppb, input string tag);
    chk(cfgn_low == RSTC, {tag, " R2 reset width"}, cfgn_low, RSTC);
    chk(first_rise - cfgn_rise_cyc >= SETC, {tag, " R3 settle"}, first_rise - cfgn_rise_cyc, SETC);
    chk(rises == n * ppb + 1, {tag, " R9 edge count"}, rises, n * ppb + 1);
    chk(end_cyc - last_rise == DONC, {tag, " R9 done wait"}, end_cyc - last_rise, DONC);
    chk(ok && !fail, {tag, " R9 ok"}, int'({ok, fail}), 2);
    chk(abort_cnt == 0, {tag, " R11 no abort"}, abort_cnt, 0);
  endtask

  task automatic t_serial();
    int errs = 0;
    run_load(2'd0, 3, 1, 1'b0);
    common_ok(3, 8, "serial");
    for (int j = 0; j < 3; j++) begin
      logic [7:0] b;
      for (int i = 0; i < 8; i++) begin
        b[i] = cap[j * 8 + i][0];
        if (cap[j * 8 + i][7:1] != 7'd0) errs++;
      end
      chk(b == src[j], "R4 serial byte", int'(b), int'(src[j]));
    end
    chk(errs == 0, "R4 upper bits zero", errs, 0);
  endtask

  task automatic t_parallel();
    run_load(2'd1, 5, 2, 1'b1);
    common_ok(5, 1, "parallel");
    for (int j = 0; j < 5; j++)
      chk(cap[j] == src[j], "R5 parallel byte", int'(cap[j]), int'(src[j]));
    chk(ok && rises == 6, "R12 start while busy ignored", rises, 6);
  endtask

  task automatic t_protected();
    int errs = 0;
    run_load(2'd2, 4, 3, 1'b0);
    common_ok(4, 4, "protected");
    for (int j = 0; j < 4; j++)
      for (int p = 0; p < 4; p++)
        if (cap[j * 4 + p] != src[j]) errs++;
    chk(errs == 0, "R6 four edges per byte", errs, 0);
  endtask

  task automatic t_hold();
    repeat (20) @(negedge clk);
    chk(ok && !fail, "R11 ok held", int'({ok, fail}), 2);
    @(negedge clk);
    clear_mon();
    mode = 2'd1; count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fail && !ok, "R11 cleared by start", int'({ok, fail}), 1);
  endtask

  task automatic t_reject(input logic [1:0] m, input int n, input string tag);
    @(negedge clk);
    clear_mon();
    mode = m; count = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fail && !ok && !busy, {tag, " R10 immediate fail"}, int'({ok, fail, busy}), 2);
    repeat (30) @(negedge clk);
    chk(cfgn_low == 0 && rises == 0, {tag, " R10 pins quiet"}, cfgn_low + rises, 0);
    chk(abort_cnt == 0 && !busy, {tag, " R10 no abort"}, abort_cnt, 0);
  endtask

  task automatic t_status_start();
    status = 1'b0;
    run_load(2'd1, 3, 4, 1'b0);
    chk(cfgn_low == RSTC, "R2 reset pulse before status fail", cfgn_low, RSTC);
    chk(rises == 0, "R8 no edges on bad status", rises, 0);
    chk(fail && !ok, "R8 fail", int'({ok, fail}), 1);
    chk(abort_cnt == 1, "R8 abort once", abort_cnt, 1);
    status = 1'b1;
  endtask

  task automatic t_status_mid();
    @(negedge clk);
    run_load_drop();
    chk(rises == 2, "R8 stop after status drop", rises, 2);
    chk(fail && !ok, "R8 mid fail", int'({ok, fail}), 1);
    chk(abort_cnt == 1, "R8 mid abort", abort_cnt, 1);
    drop_at = -1;
    status = 1'b1;
  endtask

  task automatic run_load_drop();
    int k;
    for (int i = 0; i < 32; i++) src[i] = 8'(i * 13 + 5);
    @(negedge clk);
    clear_mon();
    drop_at = 2;
    mode = 2'd1; count = CNT_W'(5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; valid = 1'b1; din = src[0];
    while (busy && k < 5) begin
      if (ready) begin
        @(posedge clk);
        k++;
        @(negedge clk);
        if (k < 5) din = src[k];
      end else @(negedge clk);
    end
    valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_done_low();
    done = 1'b0;
    run_load(2'd1, 2, 5, 1'b0);
    chk(rises == 3, "R9 trailing edge", rises, 3);
    chk(end_cyc - last_rise == DONC, "R9 wait before sample", end_cyc - last_rise, DONC);
    chk(fail && !ok, "R9 done low fail", int'({ok, fail}), 1);
    chk(abort_cnt == 1, "R9 abort once", abort_cnt, 1);
    done = 1'b1;
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_serial();
    t_parallel();
    t_protected();
    t_hold();
    t_reject(2'd3, 4, "bad mode");
    t_reject(2'd0, 0, "zero count");
    t_status_start();
    t_status_mid();
    t_done_low();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule